// File: doc/BRIEF.md
# Audio Processor Control Register Slave

This block is the two-wire serial (I2C) target that holds the settings of a television stereo audio processor. A bus master writes a register pointer byte and then one or more data bytes. The pointer is two bits wide, so it selects one of four registers: right volume, left volume, a first control word and a second control word. After each data byte the pointer steps to the next register and wraps from the last back to the first. The stored bits drive decoded control outputs to the analog path: volume codes with per-channel mute, main-output mute, line-output mute, level-control enable, attack-time select, decay-current boost, tone preset, flat-tone flag, source select, forced mono, and the effective stereo state of the line outputs. A read returns one status byte that carries the pilot-detect input and a sticky power-on flag.

The serial lines are brought into the system clock domain through a two-flop synchroniser, and edges are found there. The system clock must be at least 8 times the bus clock. The power-on reset input is the only reset. While it is high, every register holds its reset value and the bus engine waits in its idle state. At reset, the main-output mute bit is set.

The bus engine has these states. IDLE waits for a START. ADDR shifts in the address byte. If the address matches, it moves to ADDR_ACK; if not, it returns to IDLE. ADDR_ACK goes on to SUB for a write or to READ for a read. SUB shifts in the pointer byte and moves to SUB_ACK. SUB_ACK and DATA_ACK both lead to DATA. DATA shifts in a data byte, commits it, and moves to DATA_ACK. READ shifts out the status byte and moves to READ_ACK. In READ_ACK, a not-acknowledge ends the transfer and returns to IDLE. An acknowledge instead moves to READ_HOLD, which reloads the status byte and returns to READ. A START in any state enters ADDR, and a STOP in any state enters IDLE.

Top module: `aproc_ctrl_slave`

## Requirements
- R1: The 7-bit target address is 1011011 when `addr_pin_i` is 1 and 1011010 when it is 0. Any other address gets no acknowledge and changes no register.
- R2: A write is START, address with R/W=0, pointer byte, data bytes, STOP, and every byte is acknowledged. Only bits 1:0 of the pointer byte are used: 0 right volume, 1 left volume, 2 control word A, 3 control word B.
- R3: After each data byte the pointer advances by one, and it wraps from 3 to 0.
- R4: Each volume register stores bits 6:0 of its data byte and presents them as the volume code. Bit 7 of every data byte is ignored.
- R5: A channel's mute output is 1 when its volume code is below 0x30 or above 0x7B. This covers the mute step 0x2F. It is 0 for every code from 0x30 to 0x7B.
- R6: In control word A, bit 0 is the stereo request, bit 1 the main-output mute, bit 2 level-control enable, bit 3 decay boost, bits 5:4 the attack select, and bit 6 the line-output mute.
- R7: In control word B, bits 1:0 are the tone preset, bit 2 the external-source select, bit 3 forced mono, and bit 4 flat tone.
- R8: `line_stereo_o` is 1 only when `pilot_i` is 1 and bit 0 of control word A is 1.
- R9: A read returns one byte, with bit 0 the pilot-detect input and bit 1 the power-on flag.
- R10: The power-on flag is set by reset. It is cleared when the master not-acknowledges a status byte.
- R11: While `por_i` is high, the main-output mute is 1, all other control bits and both volume codes are 0 (so both channels are muted), and SDA is released.
- R12: The target pulls SDA only in acknowledge slots and for 0 bits of the status byte. It never changes SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_pin_i | input | 1 | Address bit 0 (1 when the pin is open) |
| pilot_i | input | 1 | Stereo pilot detected |
| vol_r_o | output | 7 | Right volume code |
| vol_l_o | output | 7 | Left volume code |
| mute_r_o | output | 1 | Right channel muted by its code |
| mute_l_o | output | 1 | Left channel muted by its code |
| gen_mute_o | output | 1 | Main-output mute |
| line_mute_o | output | 1 | Line-output mute |
| avl_en_o | output | 1 | Level control enable |
| avl_attack_o | output | 2 | Attack time select |
| avl_fast_decay_o | output | 1 | Decay current boost |
| tone_sel_o | output | 2 | Tone preset |
| tone_flat_o | output | 1 | Flat tone instead of preset |
| src_ext_o | output | 1 | External source selected |
| force_mono_o | output | 1 | Forced mono on main outputs |
| line_stereo_o | output | 1 | Line outputs in stereo |

## Verification
The bench writes bursts that start at every pointer value and run past register 3. A pointer that saturates instead of wrapping would leave register 0 unchanged, and one that decodes high pointer bits would write the wrong register. It probes the volume-mute decode at 0x2F, 0x30, 0x7B and 0x7C, where an off-by-one comparison flips a mute output. It reads status twice after each reset: a flag that never clears, or one cleared by the address phase instead of the not-acknowledge, returns the wrong bit 1. It also sends the address with the wrong bit 0 for the pin setting, which a design that ignores the pin would acknowledge.

// File: rtl/aproc_pkg.sv
package aproc_pkg;
    localparam int ADDR_W   = 7;
    localparam int VOL_W    = 7;
    localparam int CA_W     = 7;
    localparam int CB_W     = 5;
    localparam int REG_N    = 4;
    localparam int IDX_W    = $clog2(REG_N);
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W) + 1;
    localparam int SYNC_N   = 2;

    localparam logic [ADDR_W-2:0] ADDR_HIGH = 6'b101101;
    localparam logic [VOL_W-1:0]  VOL_LOW   = 7'h30;
    localparam logic [VOL_W-1:0]  VOL_HIGH  = 7'h7B;

    localparam logic [IDX_W-1:0] IDX_VOL_R = 2'd0;
    localparam logic [IDX_W-1:0] IDX_VOL_L = 2'd1;
    localparam logic [IDX_W-1:0] IDX_CA    = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CB    = 2'd3;

    localparam logic [CA_W-1:0] CA_RESET = 7'b000_0010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_READ_HOLD
    } state_e;
endpackage

// File: rtl/aproc_bus_sync.sv
module aproc_bus_sync #(
    parameter int STAGES = aproc_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    logic scl_prev;
    logic sda_prev;

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_prev  = scl_sh[STAGES];
    assign sda_prev  = sda_sh[STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/aproc_bus_fsm.sv
module aproc_bus_fsm
    import aproc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_pin,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                bus_start,
    input  logic                bus_stop,
    input  logic [BYTE_W-1:0]   status,
    output logic                sda_pull,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [BYTE_W-2:0]   wr_data,
    output logic                flag_clr,
    output state_e              state_o
);
    state_e              state_q;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [IDX_W-1:0]    ptr;
    logic                rw_q;
    logic [ADDR_W-1:0]   my_addr;
    logic                byte_end;

    assign my_addr  = {ADDR_HIGH, addr_pin};
    assign byte_end = scl_fall && (bit_cnt == CNT_W'(BYTE_W));

    // state register process
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
        end else if (bus_start) begin
            state_q <= ST_ADDR;
            bit_cnt <= '0;
        end else if (bus_stop) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= ST_IDLE;
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (rx_sh[BYTE_W-1:1] == my_addr) begin
                            rw_q    <= rx_sh[0];
                            state_q <= ST_ADDR_ACK;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_sh   <= status;
                            state_q <= ST_READ;
                        end else begin
                            state_q <= ST_SUB;
                        end
                    end
                end
                ST_SUB: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        ptr     <= rx_sh[IDX_W-1:0];
                        state_q <= ST_SUB_ACK;
                    end
                end
                ST_SUB_ACK: begin
                    if (scl_fall) state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        ptr     <= ptr + 1'b1;
                        state_q <= ST_DATA_ACK;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) state_q <= ST_DATA;
                end
                ST_READ: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        state_q <= ST_READ_ACK;
                    end else if (scl_fall) begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_READ_ACK: begin
                    if (scl_rise) state_q <= sda_lvl ? ST_IDLE : ST_READ_HOLD;
                end
                ST_READ_HOLD: begin
                    if (scl_fall) begin
                        tx_sh   <= status;
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        sda_pull = 1'b0;
        wr_en    = 1'b0;
        flag_clr = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_READ:     sda_pull = ~tx_sh[BYTE_W-1];
            ST_DATA:     wr_en    = byte_end && !bus_start && !bus_stop;
            ST_READ_ACK: flag_clr = scl_rise && sda_lvl && !bus_start && !bus_stop;
            default: begin
                sda_pull = 1'b0;
            end
        endcase
    end

    assign wr_idx  = ptr;
    assign wr_data = rx_sh[BYTE_W-2:0];
    assign state_o = state_q;
endmodule

// File: rtl/aproc_regfile.sv
module aproc_regfile
    import aproc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BYTE_W-2:0]  wr_data,
    input  logic               flag_clr,
    output logic               por_flag,
    output logic [VOL_W-1:0]   vol_r,
    output logic [VOL_W-1:0]   vol_l,
    output logic [1:0]         vol_mute,
    output logic [CA_W-1:0]    ctrl_a,
    output logic [CB_W-1:0]    ctrl_b
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            vol_r  <= '0;
            vol_l  <= '0;
            ctrl_a <= CA_RESET;
            ctrl_b <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                IDX_VOL_R: vol_r  <= wr_data[VOL_W-1:0];
                IDX_VOL_L: vol_l  <= wr_data[VOL_W-1:0];
                IDX_CA:    ctrl_a <= wr_data[CA_W-1:0];
                IDX_CB:    ctrl_b <= wr_data[CB_W-1:0];
                default:   ctrl_b <= ctrl_b;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)           por_flag <= 1'b1;
        else if (flag_clr) por_flag <= 1'b0;
    end

    logic [VOL_W-1:0] vol_code [2];
    assign vol_code[0] = vol_r;
    assign vol_code[1] = vol_l;

    for (genvar ch = 0; ch < 2; ch++) begin : g_vol_mute
        assign vol_mute[ch] = (vol_code[ch] < VOL_LOW) || (vol_code[ch] > VOL_HIGH);
    end
endmodule

// File: rtl/aproc_ctrl_slave.sv
module aproc_ctrl_slave
    import aproc_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             addr_pin_i,
    input  logic             pilot_i,
    output logic [VOL_W-1:0] vol_r_o,
    output logic [VOL_W-1:0] vol_l_o,
    output logic             mute_r_o,
    output logic             mute_l_o,
    output logic             gen_mute_o,
    output logic             line_mute_o,
    output logic             avl_en_o,
    output logic [1:0]       avl_attack_o,
    output logic             avl_fast_decay_o,
    output logic [1:0]       tone_sel_o,
    output logic             tone_flat_o,
    output logic             src_ext_o,
    output logic             force_mono_o,
    output logic             line_stereo_o
);
    logic               scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic               wr_en, flag_clr, por_flag;
    logic [IDX_W-1:0]   wr_idx;
    logic [BYTE_W-2:0]  wr_data;
    logic [BYTE_W-1:0]  status;
    logic [1:0]         vol_mute;
    logic [CA_W-1:0]    ctrl_a;
    logic [CB_W-1:0]    ctrl_b;
    state_e             fsm_state;

    aproc_bus_sync u_sync (
        .clk       (clk),
        .rst       (por_i),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    assign status = {{(BYTE_W-2){1'b0}}, por_flag, pilot_i};

    aproc_bus_fsm u_fsm (
        .clk       (clk),
        .rst       (por_i),
        .addr_pin  (addr_pin_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .status    (status),
        .sda_pull  (sda_pull_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .flag_clr  (flag_clr),
        .state_o   (fsm_state)
    );

    aproc_regfile u_regs (
        .clk      (clk),
        .rst      (por_i),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .por_flag (por_flag),
        .vol_r    (vol_r_o),
        .vol_l    (vol_l_o),
        .vol_mute (vol_mute),
        .ctrl_a   (ctrl_a),
        .ctrl_b   (ctrl_b)
    );

    assign mute_r_o         = vol_mute[0];
    assign mute_l_o         = vol_mute[1];
    assign line_stereo_o    = ctrl_a[0] & pilot_i;
    assign gen_mute_o       = ctrl_a[1];
    assign avl_en_o         = ctrl_a[2];
    assign avl_fast_decay_o = ctrl_a[3];
    assign avl_attack_o     = ctrl_a[5:4];
    assign line_mute_o      = ctrl_a[6];
    assign tone_sel_o       = ctrl_b[1:0];
    assign src_ext_o        = ctrl_b[2];
    assign force_mono_o     = ctrl_b[3];
    assign tone_flat_o      = ctrl_b[4];
endmodule

// File: rtl/aproc_ctrl_checker.sv
module aproc_ctrl_checker
    import aproc_pkg::*;
(
    input logic             clk,
    input logic             por_i,
    input logic             scl_lvl,
    input logic             sda_pull_o,
    input logic             wr_en,
    input logic             por_flag,
    input state_e           fsm_state,
    input logic             gen_mute_o,
    input logic [VOL_W-1:0] vol_r_o,
    input logic [VOL_W-1:0] vol_l_o,
    input logic [1:0]       tone_sel_o,
    input logic             avl_en_o
);
    p_reset_mute_r11: assert property (@(posedge clk) por_i |-> gen_mute_o);

    p_sda_steady_r12: assert property (@(posedge clk) disable iff (por_i)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull_o));

    p_one_commit_r3: assert property (@(posedge clk) disable iff (por_i)
        wr_en |=> !wr_en);

    p_hold_unwritten_r2: assert property (@(posedge clk) disable iff (por_i)
        !$past(wr_en) |-> $stable({vol_r_o, vol_l_o, gen_mute_o, avl_en_o, tone_sel_o}));

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (por_i)
        $fell(por_flag) |-> $past(fsm_state == ST_READ_ACK));
endmodule

bind aproc_ctrl_slave aproc_ctrl_checker u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .scl_lvl    (scl_lvl),
    .sda_pull_o (sda_pull_o),
    .wr_en      (wr_en),
    .por_flag   (por_flag),
    .fsm_state  (fsm_state),
    .gen_mute_o (gen_mute_o),
    .vol_r_o    (vol_r_o),
    .vol_l_o    (vol_l_o),
    .tone_sel_o (tone_sel_o),
    .avl_en_o   (avl_en_o)
);

// File: tb/test_aproc_ctrl_slave.sv
module test_aproc_ctrl_slave;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic por, scl_m, sda_m, addr_pin, pilot;
    logic sda_pull;
    logic sda_line;
    logic [6:0] vol_r, vol_l;
    logic mute_r, mute_l, gen_mute, line_mute, avl_en, fast_decay, tone_flat, src_ext, mono, line_st;
    logic [1:0] attack, tone_sel;

    assign sda_line = sda_m & ~sda_pull;

    aproc_ctrl_slave i_aproc_ctrl_slave (
        .clk(clk), .por_i(por), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .addr_pin_i(addr_pin), .pilot_i(pilot), .vol_r_o(vol_r), .vol_l_o(vol_l),
        .mute_r_o(mute_r), .mute_l_o(mute_l), .gen_mute_o(gen_mute), .line_mute_o(line_mute),
        .avl_en_o(avl_en), .avl_attack_o(attack), .avl_fast_decay_o(fast_decay),
        .tone_sel_o(tone_sel), .tone_flat_o(tone_flat), .src_ext_o(src_ext),
        .force_mono_o(mono), .line_stereo_o(line_st)
    );

    int checks = 0;
    int errors = 0;
    logic [6:0] exp_reg [4];
    logic [7:0] wbuf [4];

    function automatic logic exp_mute(input logic [6:0] c);
        return (c < 7'h30) || (c > 7'h7B);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        exp_reg[0] = 7'h00; exp_reg[1] = 7'h00; exp_reg[2] = 7'h02; exp_reg[3] = 7'h00;
    endtask

    task automatic model_write(input logic [7:0] sub, input int n);
        logic [1:0] idx = sub[1:0];
        for (int k = 0; k < n; k++) begin
            exp_reg[idx] = (idx == 2'd3) ? {2'b00, wbuf[k][4:0]} : wbuf[k][6:0];
            idx = idx + 2'd1;
        end
    endtask

    task automatic check_all(input string req);
        tick(4);
        chk(req, "vol_r R4", vol_r, exp_reg[0]);
        chk(req, "vol_l R4", vol_l, exp_reg[1]);
        chk(req, "mute_r R5", mute_r, exp_mute(exp_reg[0]));
        chk(req, "mute_l R5", mute_l, exp_mute(exp_reg[1]));
        chk(req, "ctrlA R6", {line_mute, attack, fast_decay, avl_en, gen_mute}, exp_reg[2][6:1]);
        chk(req, "ctrlB R7", {tone_flat, mono, src_ext, tone_sel}, exp_reg[3][4:0]);
        chk(req, "line_stereo R8", line_st, pilot & exp_reg[2][0]);
        chk(req, "sda released R12", sda_pull, 1'b0);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_write(input logic [6:0] a, input logic [7:0] sub, input int n, output logic acked);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        acked = ack;
        if (ack) begin
            send_byte(sub, ack);
            for (int k = 0; k < n; k++) send_byte(wbuf[k], ack);
        end
        bus_stop();
    endtask

    task automatic i2c_read(input logic [6:0] a, output logic acked, output logic [7:0] d);
        logic ack;
        d = 8'h00;
        bus_start();
        send_byte({a, 1'b1}, ack);
        acked = ack;
        if (ack) recv_byte(d, 1'b1);
        bus_stop();
    endtask

    task automatic apply_por();
        por = 1'b1; tick(5);
        model_reset();
        chk("R11", "gen_mute in reset", gen_mute, 1'b1);
        chk("R11", "volumes in reset", {vol_r, vol_l}, 14'h0);
        chk("R11", "mutes in reset", {mute_r, mute_l}, 2'b11);
        chk("R11", "controls in reset", {line_mute, attack, fast_decay, avl_en, tone_flat, mono, src_ext, tone_sel, line_st}, 11'h0);
        chk("R11", "sda in reset", sda_pull, 1'b0);
        por = 1'b0; tick(5);
    endtask

    task automatic write_one(input logic [7:0] sub, input logic [7:0] d);
        logic acked;
        wbuf[0] = d;
        i2c_write(7'h5B, sub, 1, acked);
        chk("R2", "ack single write", acked, 1'b1);
        model_write(sub, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic acked;
        logic [7:0] rd;
        int seed_dummy;
        seed_dummy = $urandom(32'h0A5D_1234);
        por = 1'b1; scl_m = 1'b1; sda_m = 1'b1; addr_pin = 1'b1; pilot = 1'b1;
        tick(3);
        apply_por();
        check_all("R11");

        // status reads: flag set after reset, cleared after first NACKed read
        i2c_read(7'h5B, acked, rd);
        chk("R9", "read ack", acked, 1'b1);
        chk("R10", "first status", rd[1:0], 2'b11);
        i2c_read(7'h5B, acked, rd);
        chk("R10", "flag cleared", rd[1:0], 2'b01);
        pilot = 1'b0;
        i2c_read(7'h5B, acked, rd);
        chk("R9", "pilot low status", rd[1:0], 2'b00);
        pilot = 1'b1;

        // full burst from 0, MSBs set to prove they are ignored
        wbuf[0] = 8'hEF; wbuf[1] = 8'hFB; wbuf[2] = 8'hB5; wbuf[3] = 8'hFE;
        i2c_write(7'h5B, 8'h00, 4, acked);
        chk("R2", "burst ack", acked, 1'b1);
        model_write(8'h00, 4);
        check_all("R3 R4 R6 R7");

        // wrap from 3 to 0
        wbuf[0] = 8'h15; wbuf[1] = 8'h40;
        i2c_write(7'h5B, 8'h03, 2, acked);
        model_write(8'h03, 2);
        check_all("R3 wrap");

        // upper pointer bits ignored
        write_one(8'hFE, 8'h4A);
        check_all("R2 pointer bits");

        // address selection by pin
        wbuf[0] = 8'h55;
        i2c_write(7'h5A, 8'h00, 1, acked);
        chk("R1", "wrong address nack", acked, 1'b0);
        check_all("R1 no change");
        addr_pin = 1'b0;
        i2c_write(7'h5B, 8'h00, 1, acked);
        chk("R1", "open-pin address nack when tied", acked, 1'b0);
        wbuf[0] = 8'h66;
        i2c_write(7'h5A, 8'h01, 1, acked);
        chk("R1", "tied address ack", acked, 1'b1);
        model_write(8'h01, 1);
        check_all("R1 write");
        addr_pin = 1'b1;

        // volume boundaries
        write_one(8'h00, 8'h2F); check_all("R5 0x2F");
        write_one(8'h00, 8'h30); check_all("R5 0x30");
        write_one(8'h01, 8'h7B); check_all("R5 0x7B");
        write_one(8'h01, 8'h7C); check_all("R5 0x7C");

        // stereo line-out combinations
        write_one(8'h02, 8'h01);
        pilot = 1'b1; check_all("R8 both");
        pilot = 1'b0; check_all("R8 no pilot");
        write_one(8'h02, 8'h00);
        pilot = 1'b1; check_all("R8 no request");

        // random bursts
        for (int t = 0; t < 14; t++) begin
            logic [7:0] sub;
            int n;
            sub = 8'($urandom);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
            pilot = 1'($urandom);
            i2c_write(7'h5B, sub, n, acked);
            chk("R2", "random ack", acked, 1'b1);
            model_write(sub, n);
            check_all("R3 random");
        end

        // second power-on: flag set again
        apply_por();
        check_all("R11 again");
        i2c_read(7'h5B, acked, rd);
        chk("R10", "flag after second reset", rd[1], 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule